// File: doc/BRIEF.md
# Pointer-Based Address Generation Unit

This unit forms the effective data-space address for every load or store of a small 8-bit processor. A request names an addressing mode, one of three 16-bit pointers, and a short immediate. The pointers are built from the six top general registers, taken as three low/high byte pairs. The unit accepts a request on a clock edge and presents the result on the next cycle. The result is the effective address, together with an optional pointer update that the register file writes back into the chosen pair.

Two direct forms reach small fixed regions. An I/O form covers the 64 locations at the bottom of the space. A short direct form covers a 128-byte window that starts just above it. The three indirect forms use a pointer and can reach the whole 16-bit space. The pre-decrement form lowers the pointer first and then uses the lowered value as the address. The post-increment form uses the pointer as it is and then raises it. Both forms return the new pointer value split into its two bytes. Instruction decode and the memory bus sit outside this unit.

Top module: `agu_addr_gen`

## Requirements
- R1: While `rst_n` is low at a rising edge, the following edge leaves `ea_valid`, `wb_en`, `ea_addr`, `wb_ptr`, `wb_lo` and `wb_hi` all at zero.
- R2: A request accepted at one edge sets `ea_valid` at that same edge and holds it for one cycle. With no accepted request, `ea_valid` and `wb_en` are low, and `ea_addr`, `wb_ptr`, `wb_lo` and `wb_hi` keep their last values.
- R3: Mode code 0 (I/O form) gives `ea_addr` = `imm[5:0]` zero-extended, so the address always falls within 0x0000–0x003F. `imm[6]` has no effect.
- R4: Mode code 1 (short direct form) gives `ea_addr` = 0x0040 + `imm[6:0]`, so the address always falls within 0x0040–0x00BF.
- R5: Pointer select 0 picks X = `pair_regs[15:0]` (R27:R26), select 1 picks Y = `pair_regs[31:16]` (R29:R28), and select 2 picks Z = `pair_regs[47:32]` (R31:R30), with the high byte in the upper half of each pair. Select 3 in a pointer mode (codes 2–4) drops the request: no `ea_valid` and no `wb_en`.
- R6: Mode code 2 (plain indirect) gives `ea_addr` = the selected pointer.
- R7: Mode code 3 (pre-decrement) gives `ea_addr` = pointer − 1. It also raises `wb_en`, writes the same value as {`wb_hi`,`wb_lo`}, and sets `wb_ptr` = the select.
- R8: Mode code 4 (post-increment) gives `ea_addr` = pointer. It also raises `wb_en` with {`wb_hi`,`wb_lo`} = pointer + 1 and `wb_ptr` = the select.
- R9: Pointer arithmetic wraps modulo 2^16: 0x0000 pre-decremented gives 0xFFFF, and 0xFFFF post-incremented writes back 0x0000.
- R10: Mode codes 5–7 are reserved. A request that carries one is dropped: no `ea_valid` and no `wb_en`.
- R11: `wb_en` is never raised for mode codes 0, 1 or 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| mode | input | 3 | Addressing mode code (0..4 defined) |
| ptr_sel | input | 2 | Pointer select: 0=X, 1=Y, 2=Z |
| imm | input | 7 | Short immediate / I/O index |
| pair_regs | input | 48 | {R31,R30,R29,R28,R27,R26} |
| ea_valid | output | 1 | Effective address valid |
| ea_addr | output | 16 | Effective address |
| wb_en | output | 1 | Pointer write-back enable |
| wb_ptr | output | 2 | Pointer pair to write back |
| wb_lo | output | 8 | New low byte of the pointer |
| wb_hi | output | 8 | New high byte of the pointer |

## Verification
The assertions check on every cycle that the two direct forms stay inside their windows. They also check that a write-back never appears without a valid address or after a non-modifying mode, and that the written pointer stands in the right relation to the address: equal to it for pre-decrement, one above it for post-increment. They also check that an illegal select or a reserved mode is dropped. The exact address values are shown only by the bench's reference model and its scenarios. Those values are pointer selection from the right byte pair, the wrap at both ends of the space, the ignored immediate bit in the I/O form, and the holding of outputs across idle cycles.

// File: rtl/agu_pkg.sv
// Package: shared mode codes for the address generation unit.
// Assumes the mode field is 3 bits wide; codes 5..7 are reserved.
package agu_pkg;
    typedef enum logic [2:0] {
        AM_IO      = 3'd0,
        AM_SHORT   = 3'd1,
        AM_IND     = 3'd2,
        AM_PREDEC  = 3'd3,
        AM_POSTINC = 3'd4
    } am_e;

    localparam int unsigned MODE_W = 3;
endpackage

// File: rtl/agu_ptr_mux.sv
// agu_ptr_mux: picks one 16-bit pointer out of the packed register pairs.
// Assumes pairs are packed lowest pointer first, low byte below high byte.
// sel_ok is low when the select names no existing pointer.
module agu_ptr_mux #(
    parameter int unsigned REG_W = 8,
    parameter int unsigned NPTR  = 3,
    localparam int unsigned PTR_W = 2 * REG_W,
    localparam int unsigned SEL_W = (NPTR > 1) ? $clog2(NPTR) : 1
) (
    input  logic [NPTR*PTR_W-1:0] pairs,
    input  logic [SEL_W-1:0]      sel,
    output logic [PTR_W-1:0]      ptr,
    output logic                  sel_ok
);
    logic [PTR_W-1:0] ptr_arr [NPTR];

    genvar gi;
    generate
        for (gi = 0; gi < NPTR; gi++) begin : g_pair
            assign ptr_arr[gi] = pairs[gi*PTR_W +: PTR_W];
        end
    endgenerate

    // Select the addressed pair, or zero for an out-of-range select.
    always_comb begin
        ptr    = '0;
        sel_ok = 1'b0;
        for (int i = 0; i < NPTR; i++) begin
            if (sel == SEL_W'(i)) begin
                ptr    = ptr_arr[i];
                sel_ok = 1'b1;
            end
        end
    end
endmodule

// File: rtl/agu_ptr_arith.sv
// agu_ptr_arith: one-step pointer increment and decrement.
// Assumes arithmetic wraps modulo 2^W; no carry out is kept.
module agu_ptr_arith #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] ptr,
    output logic [W-1:0] ptr_inc,
    output logic [W-1:0] ptr_dec
);
    // Both neighbours are formed in parallel; the selector picks one.
    always_comb begin
        ptr_inc = ptr + W'(1);
        ptr_dec = ptr - W'(1);
    end
endmodule

// File: rtl/agu_ea_sel.sv
// agu_ea_sel: combinational choice of effective address and write-back value.
// Assumes the pointer and its neighbours are already formed upstream.
// accept is low for reserved modes and for pointer modes with a bad select.
module agu_ea_sel
    import agu_pkg::*;
#(
    parameter int unsigned ADDR_W  = 16,
    parameter int unsigned IMM_W   = 7,
    parameter int unsigned IO_BITS = 6,
    parameter logic [ADDR_W-1:0] SD_BASE = 16'h0040
) (
    input  logic [MODE_W-1:0] mode,
    input  logic [IMM_W-1:0]  imm,
    input  logic [ADDR_W-1:0] ptr,
    input  logic [ADDR_W-1:0] ptr_inc,
    input  logic [ADDR_W-1:0] ptr_dec,
    input  logic              sel_ok,
    output logic [ADDR_W-1:0] ea,
    output logic [ADDR_W-1:0] wb_val,
    output logic              wb_want,
    output logic              accept
);
    logic [ADDR_W-1:0] io_ea;
    logic [ADDR_W-1:0] sd_ea;

    // Direct-form addresses from the immediate.
    always_comb begin
        io_ea = ADDR_W'(imm[IO_BITS-1:0]);
        sd_ea = SD_BASE + ADDR_W'(imm);
    end

    // Mode decode: address, update value and legality.
    always_comb begin
        ea      = '0;
        wb_val  = '0;
        wb_want = 1'b0;
        accept  = 1'b0;
        case (mode)
            AM_IO: begin
                ea     = io_ea;
                accept = 1'b1;
            end
            AM_SHORT: begin
                ea     = sd_ea;
                accept = 1'b1;
            end
            AM_IND: begin
                ea     = ptr;
                accept = sel_ok;
            end
            AM_PREDEC: begin
                ea      = ptr_dec;
                wb_val  = ptr_dec;
                wb_want = 1'b1;
                accept  = sel_ok;
            end
            AM_POSTINC: begin
                ea      = ptr;
                wb_val  = ptr_inc;
                wb_want = 1'b1;
                accept  = sel_ok;
            end
            default: begin
                accept = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/agu_addr_gen.sv
// agu_addr_gen: top of the address generation unit.
// Registers one result per accepted request; outputs appear one cycle
// after the request. Address and write-back fields hold when idle.
// Assumes synchronous active-low reset and a single clock.
module agu_addr_gen
    import agu_pkg::*;
#(
    parameter int unsigned REG_W   = 8,
    parameter int unsigned NPTR    = 3,
    parameter int unsigned IMM_W   = 7,
    parameter int unsigned IO_BITS = 6,
    parameter logic [2*REG_W-1:0] SD_BASE = 16'h0040,
    localparam int unsigned ADDR_W = 2 * REG_W,
    localparam int unsigned SEL_W  = (NPTR > 1) ? $clog2(NPTR) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic [MODE_W-1:0]      mode,
    input  logic [SEL_W-1:0]       ptr_sel,
    input  logic [IMM_W-1:0]       imm,
    input  logic [NPTR*ADDR_W-1:0] pair_regs,
    output logic                   ea_valid,
    output logic [ADDR_W-1:0]      ea_addr,
    output logic                   wb_en,
    output logic [SEL_W-1:0]       wb_ptr,
    output logic [REG_W-1:0]       wb_lo,
    output logic [REG_W-1:0]       wb_hi
);
    logic [ADDR_W-1:0] ptr, ptr_inc, ptr_dec, ea_c, wb_val_c;
    logic              sel_ok, wb_want_c, accept_c, take;

    agu_ptr_mux #(.REG_W(REG_W), .NPTR(NPTR)) u_mux (
        .pairs  (pair_regs),
        .sel    (ptr_sel),
        .ptr    (ptr),
        .sel_ok (sel_ok)
    );

    agu_ptr_arith #(.W(ADDR_W)) u_arith (
        .ptr     (ptr),
        .ptr_inc (ptr_inc),
        .ptr_dec (ptr_dec)
    );

    agu_ea_sel #(
        .ADDR_W(ADDR_W), .IMM_W(IMM_W), .IO_BITS(IO_BITS), .SD_BASE(SD_BASE)
    ) u_sel (
        .mode    (mode),
        .imm     (imm),
        .ptr     (ptr),
        .ptr_inc (ptr_inc),
        .ptr_dec (ptr_dec),
        .sel_ok  (sel_ok),
        .ea      (ea_c),
        .wb_val  (wb_val_c),
        .wb_want (wb_want_c),
        .accept  (accept_c)
    );

    assign take = req_valid && accept_c;

    // Result register: strobes pulse per request, data fields hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ea_valid <= 1'b0;
            ea_addr  <= '0;
            wb_en    <= 1'b0;
            wb_ptr   <= '0;
            wb_lo    <= '0;
            wb_hi    <= '0;
        end else begin
            ea_valid <= take;
            wb_en    <= take && wb_want_c;
            if (take) begin
                ea_addr <= ea_c;
            end
            if (take && wb_want_c) begin
                wb_ptr <= ptr_sel;
                wb_lo  <= wb_val_c[REG_W-1:0];
                wb_hi  <= wb_val_c[ADDR_W-1:REG_W];
            end
        end
    end

    // I/O form stays inside the bottom I/O window.
    assert_io_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mode == AM_IO) |=> (ea_valid && ea_addr < ADDR_W'(64)));

    // Short direct form stays inside its 128-byte window.
    assert_short_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mode == AM_SHORT) |=>
        (ea_valid && ea_addr >= ADDR_W'(16'h0040) && ea_addr <= ADDR_W'(16'h00BF)));

    // Bad pointer select in a pointer mode is dropped.
    assert_bad_sel_dropped_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ptr_sel >= SEL_W'(NPTR) && mode inside {AM_IND, AM_PREDEC, AM_POSTINC})
        |=> (!ea_valid && !wb_en));

    // Pre-decrement writes back exactly the address used.
    assert_predec_wb_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mode == AM_PREDEC && ptr_sel < SEL_W'(NPTR)) |=>
        (wb_en && {wb_hi, wb_lo} == ea_addr));

    // Post-increment writes back one above the address, wrapping.
    assert_postinc_wb_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mode == AM_POSTINC && ptr_sel < SEL_W'(NPTR)) |=>
        (wb_en && {wb_hi, wb_lo} == ADDR_W'(ea_addr + ADDR_W'(1))));

    // Reserved mode codes produce nothing.
    assert_reserved_dropped_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mode > MODE_W'(4)) |=> (!ea_valid && !wb_en));

    // Non-modifying modes never request a write-back.
    assert_no_wb_plain_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mode inside {AM_IO, AM_SHORT, AM_IND}) |=> !wb_en);

    // A write-back always accompanies a valid address.
    assert_wb_with_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> ea_valid);
endmodule

// File: tb/agu_addr_gen_tb.sv
`timescale 1ns/1ps
module agu_addr_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [2:0]  mode;
    logic [1:0]  ptr_sel;
    logic [6:0]  imm;
    logic [47:0] pair_regs;
    logic        ea_valid, wb_en;
    logic [15:0] ea_addr;
    logic [1:0]  wb_ptr;
    logic [7:0]  wb_lo, wb_hi;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    // Reference state: what the outputs must read after the next edge.
    logic        x_valid, x_wben;
    logic [15:0] x_ea;
    logic [1:0]  x_wbp;
    logic [15:0] x_wbv;
    string       x_tag;

    always #4 clk = ~clk;

    agu_addr_gen u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mode(mode),
        .ptr_sel(ptr_sel), .imm(imm), .pair_regs(pair_regs),
        .ea_valid(ea_valid), .ea_addr(ea_addr), .wb_en(wb_en),
        .wb_ptr(wb_ptr), .wb_lo(wb_lo), .wb_hi(wb_hi)
    );

    task automatic compare();
        checks++;
        if (ea_valid !== x_valid || ea_addr !== x_ea || wb_en !== x_wben ||
            wb_ptr !== x_wbp || {wb_hi, wb_lo} !== x_wbv) begin
            errors++;
            $display("FAIL %s: got v=%0b ea=%04h we=%0b p=%0d wb=%04h exp v=%0b ea=%04h we=%0b p=%0d wb=%04h",
                     x_tag, ea_valid, ea_addr, wb_en, wb_ptr, {wb_hi, wb_lo},
                     x_valid, x_ea, x_wben, x_wbp, x_wbv);
        end
    endtask

    // Behavioural model of one edge given the inputs now applied.
    task automatic model();
        logic [15:0] p;
        int m;
        int s;
        m = int'(mode);
        s = int'(ptr_sel);
        p = (s < 3) ? pair_regs[s*16 +: 16] : 16'h0;
        if (!rst_n) begin
            x_valid = 0; x_wben = 0; x_ea = 0; x_wbp = 0; x_wbv = 0; x_tag = "R1";
        end else if (req_valid && (m <= 1 || (m <= 4 && s < 3))) begin
            x_valid = 1;
            x_wben  = (m == 3 || m == 4);
            case (m)
                0: begin x_ea = {10'b0, imm[5:0]}; x_tag = "R3,R11"; end
                1: begin x_ea = 16'h0040 + {9'b0, imm}; x_tag = "R4,R11"; end
                2: begin x_ea = p; x_tag = "R6,R5,R11"; end
                3: begin
                    x_ea = p - 16'd1; x_wbv = p - 16'd1; x_wbp = ptr_sel;
                    x_tag = (p == 16'h0000) ? "R9,R7" : "R7,R5";
                end
                default: begin
                    x_ea = p; x_wbv = p + 16'd1; x_wbp = ptr_sel;
                    x_tag = (p == 16'hFFFF) ? "R9,R8" : "R8,R5";
                end
            endcase
        end else begin
            x_valid = 0; x_wben = 0;
            if (req_valid && m > 4) x_tag = "R10";
            else if (req_valid) x_tag = "R5";
            else x_tag = "R2";
        end
    endtask

    task automatic drive(input logic r, input logic v, input int m, input int s,
                         input logic [6:0] im, input logic [47:0] pr);
        @(negedge clk);
        if (x_tag != "") compare();
        rst_n = r; req_valid = v; mode = 3'(m); ptr_sel = 2'(s); imm = im; pair_regs = pr;
        model();
    endtask

    localparam logic [47:0] PAIRS_A = 48'hC3D4_A1B2_1234;  // Z, Y, X

    initial begin
        x_tag = "";
        rst_n = 0; req_valid = 1; mode = 3; ptr_sel = 0; imm = 7'h7F; pair_regs = PAIRS_A;
        drive(0, 1, 3, 0, 7'h7F, PAIRS_A);
        drive(0, 1, 4, 1, 7'h11, PAIRS_A);           // R1 reset dominates
        drive(1, 0, 0, 0, 7'h00, PAIRS_A);           // reset state observed
        drive(1, 1, 0, 0, 7'h2A, PAIRS_A);           // R3
        drive(1, 1, 0, 0, 7'h6A, PAIRS_A);           // R3 bit 6 ignored
        drive(1, 1, 0, 0, 7'h3F, PAIRS_A);           // R3 top of window
        drive(1, 1, 1, 0, 7'h00, PAIRS_A);           // R4 low edge
        drive(1, 1, 1, 0, 7'h7F, PAIRS_A);           // R4 high edge
        drive(1, 1, 2, 0, 7'h00, PAIRS_A);           // R6/R5 X
        drive(1, 1, 2, 1, 7'h00, PAIRS_A);           // Y
        drive(1, 1, 2, 2, 7'h00, PAIRS_A);           // Z
        drive(1, 1, 3, 1, 7'h00, PAIRS_A);           // R7
        drive(1, 0, 3, 1, 7'h00, PAIRS_A);           // R2 idle hold
        drive(1, 0, 0, 0, 7'h00, PAIRS_A);           // R2 idle hold
        drive(1, 1, 4, 2, 7'h00, PAIRS_A);           // R8
        drive(1, 1, 3, 0, 7'h00, 48'h0001_0002_0000); // R9 predec wrap
        drive(1, 1, 4, 1, 7'h00, 48'h0001_FFFF_0000); // R9 postinc wrap
        drive(1, 1, 2, 3, 7'h00, PAIRS_A);           // R5 bad select
        drive(1, 1, 3, 3, 7'h00, PAIRS_A);           // R5 bad select
        drive(1, 1, 5, 0, 7'h10, PAIRS_A);           // R10
        drive(1, 1, 6, 1, 7'h10, PAIRS_A);           // R10
        drive(1, 1, 7, 2, 7'h10, PAIRS_A);           // R10
        for (int i = 0; i < 300; i++) begin
            drive(1, 1'($urandom), int'($urandom_range(0, 7)), int'($urandom_range(0, 3)),
                  7'($urandom), {$urandom, $urandom}[47:0]);
        end
        drive(0, 0, 0, 0, 7'h00, PAIRS_A);
        drive(1, 0, 0, 0, 7'h00, PAIRS_A);
        drive(1, 0, 0, 0, 7'h00, PAIRS_A);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got hang exp completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule